// File: doc/BRIEF.md
# Link Power State Controller

This block is the link power-management sequencer for one end of a serial point-to-point interconnect link. It follows the link through its active, standby, low-power, pre-removal and off states. It also keeps the link inside the set of states that the device's current power state allows. The transmit and receive directions enter and leave the fast standby state (L0s) on their own whenever their direction is idle. The deeper L1 state is entered only on a directed request, or because the device has left its fully-on state, and only when nothing is outstanding.

The controller drives per-direction electrical-idle enables, a PLL shutdown enable and a clock-gate enable. Exit latencies from L0s and L1 are modelled with cycle counters whose lengths come in on ports. Each exit ends with a one-cycle ready pulse. From D3hot, a power-removal request takes the link through L2/L3-Ready. From there it falls to L2 when auxiliary power is present and to L3 when it is not. L2 is left only on the wake signal, and L3 only when power, clock and reset have been reapplied.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset, `link_state` is 0, both idle enables, `pll_off`, `clk_gate`, `exit_ready` and `pm_err` are 0. The `link_state` codes are 0 = L0, 1 = L0s, 2 = L1 (including its exit window), 3 = L2/L3-Ready, 4 = L2, 5 = L3. The `dev_state` codes are 0 = D0, 1 = D1, 2 = D2, 3 = D3hot.
- R2: In L0 with `dev_state` 0, a direction whose idle input is high has its electrical-idle enable asserted from the next cycle, and `link_state` reads 1. Each direction acts on its own input only.
- R3: When a standby direction's idle input drops, its idle enable stays high for max(`l0s_exit_cyc`,1) cycles. It then falls, and `exit_ready` pulses for one cycle while the link is still L0 or L0s.
- R4: While `dev_state` is not 0, no direction enters L0s. A direction already in L0s starts its exit when `dev_state` leaves 0.
- R5: From L0 or L0s the link moves to L1 in the cycle after `no_pending` is high together with either `l1_req` high or `dev_state` non-zero. While `no_pending` is low, the link stays in L0.
- R6: In L1, L2/L3-Ready, L2 and L3, both idle enables, `pll_off` and `clk_gate` are high.
- R7: L1 is left only when `dev_state` is 0 and `l1_req` is low. For max(`l1_exit_cyc`,1) cycles the link reads 2 with `pll_off` low and `clk_gate` and both idle enables high. Then it returns to L0 with a one-cycle `exit_ready` pulse.
- R8: `remove_req` in L1 with `dev_state` 3 moves the link to L2/L3-Ready. It stays there while `remove_req` is held. When the request is released it moves to L2 if `aux_present` is high, otherwise to L3.
- R9: L2 is left, to L0 with no ready pulse, only in the cycle after `wake_n` is low. `pwr_restored` has no effect there.
- R10: L3 is left, to L0, only in the cycle after `pwr_restored` is high. `wake_n` has no effect there.
- R11: `remove_req` in L0, L0s or during the L1 exit window, or in L1 with `dev_state` other than 3, leaves the link state unchanged and sets `pm_err`. `pm_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_state | input | 2 | Device power state (0 D0, 1 D1, 2 D2, 3 D3hot) |
| tx_idle | input | 1 | Transmit direction has nothing to send |
| rx_idle | input | 1 | Receive direction sees no traffic |
| l1_req | input | 1 | Directed request to hold the link in L1 |
| no_pending | input | 1 | No requests or transactions outstanding |
| remove_req | input | 1 | Prepare for power and clock removal |
| aux_present | input | 1 | Auxiliary power is available |
| wake_n | input | 1 | Wake signal, active low |
| pwr_restored | input | 1 | Power, clock and reset have been reapplied |
| l0s_exit_cyc | input | CNT_W | L0s exit latency in cycles |
| l1_exit_cyc | input | CNT_W | L1 exit latency in cycles |
| link_state | output | 3 | Current link state code |
| tx_eidle | output | 1 | Transmit electrical-idle enable |
| rx_eidle | output | 1 | Receive electrical-idle enable |
| pll_off | output | 1 | PLL shutdown enable |
| clk_gate | output | 1 | Logic clock-gate enable |
| exit_ready | output | 1 | One-cycle pulse when an L0s or L1 exit completes |
| pm_err | output | 1 | Sticky illegal-request flag |

## Verification
The bench builds the block with `CNT_W` = 4. The exit lengths are driven to 3 cycles for L0s and 6 for L1. Later the L0s length is set to 0, which exercises the clamp to a one-cycle exit without long waits. The narrow counter keeps every exit window short enough that each directional overlap can be seen within a few cycles: one lane waking while the other stays idle, a D-state change during standby, and L1 entry with pending traffic. L2 and L3 are reached from the same run.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;

  typedef enum logic [1:0] {
    DEV_ON   = 2'd0,
    DEV_LITE = 2'd1,
    DEV_DEEP = 2'd2,
    DEV_HOT  = 2'd3
  } dev_pwr_e;

  typedef enum logic [2:0] {
    CODE_ACTIVE = 3'd0,
    CODE_STBY   = 3'd1,
    CODE_LOW    = 3'd2,
    CODE_PREOFF = 3'd3,
    CODE_AUXOFF = 3'd4,
    CODE_DEAD   = 3'd5
  } link_code_e;

  typedef enum logic [2:0] {
    MS_ACTIVE,
    MS_LOW,
    MS_LOW_EXIT,
    MS_PREOFF,
    MS_AUXOFF,
    MS_DEAD
  } main_st_e;

  typedef enum logic [1:0] {
    LN_ON,
    LN_IDLE,
    LN_WAKE
  } lane_st_e;

endpackage

// File: rtl/link_pm_exit_timer.sv
module link_pm_exit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (len == '0) ? CNT_W'(1) : len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign cnt_en = load || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/link_pm_lane.sv
module link_pm_lane
  import link_pm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             force_on,
  input  logic             idle,
  input  logic [CNT_W-1:0] exit_len,
  output logic             eidle,
  output logic             rdy
);

  lane_st_e st_q;
  lane_st_e st_d;
  logic     tmr_load;
  logic     tmr_done;
  logic     rdy_d;
  logic     rdy_q;

  link_pm_exit_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .len  (exit_len),
    .done (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    unique case (st_q)
      LN_ON: begin
        if (allow && idle) st_d = LN_IDLE;
      end
      LN_IDLE: begin
        if (!idle || !allow) begin
          st_d     = LN_WAKE;
          tmr_load = 1'b1;
        end
      end
      LN_WAKE: begin
        if (tmr_done) st_d = LN_ON;
      end
      default: st_d = LN_ON;
    endcase
    if (force_on) begin
      st_d     = LN_ON;
      tmr_load = 1'b0;
    end
  end

  assign rdy_d = (st_q == LN_WAKE) && tmr_done && !force_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_ON;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= rdy_d;
    end
  end

  assign eidle = (st_q != LN_ON);
  assign rdy   = rdy_q;

endmodule

// File: rtl/link_pm_main_fsm.sv
module link_pm_main_fsm
  import link_pm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dev_state,
  input  logic             l1_req,
  input  logic             no_pending,
  input  logic             remove_req,
  input  logic             aux_present,
  input  logic             wake_n,
  input  logic             pwr_restored,
  input  logic [CNT_W-1:0] exit_len,
  output main_st_e         state,
  output logic             rdy,
  output logic             err
);

  main_st_e st_q;
  main_st_e st_d;
  logic     tmr_load;
  logic     tmr_done;
  logic     err_set;
  logic     err_q;
  logic     rdy_q;
  logic     dev_on;
  logic     dev_hot;

  assign dev_on  = (dev_state == DEV_ON);
  assign dev_hot = (dev_state == DEV_HOT);

  link_pm_exit_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .len  (exit_len),
    .done (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    err_set  = 1'b0;
    unique case (st_q)
      MS_ACTIVE: begin
        if (remove_req) err_set = 1'b1;
        if ((l1_req || !dev_on) && no_pending) st_d = MS_LOW;
      end
      MS_LOW: begin
        if (remove_req) begin
          if (dev_hot) st_d = MS_PREOFF;
          else         err_set = 1'b1;
        end else if (dev_on && !l1_req) begin
          st_d     = MS_LOW_EXIT;
          tmr_load = 1'b1;
        end
      end
      MS_LOW_EXIT: begin
        if (remove_req) err_set = 1'b1;
        if (tmr_done) st_d = MS_ACTIVE;
      end
      MS_PREOFF: begin
        if (!remove_req) st_d = aux_present ? MS_AUXOFF : MS_DEAD;
      end
      MS_AUXOFF: begin
        if (!wake_n) st_d = MS_ACTIVE;
      end
      MS_DEAD: begin
        if (pwr_restored) st_d = MS_ACTIVE;
      end
      default: st_d = MS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_ACTIVE;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= (st_q == MS_LOW_EXIT) && tmr_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  assign state = st_q;
  assign rdy   = rdy_q;
  assign err   = err_q;

endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dev_state,
  input  logic             tx_idle,
  input  logic             rx_idle,
  input  logic             l1_req,
  input  logic             no_pending,
  input  logic             remove_req,
  input  logic             aux_present,
  input  logic             wake_n,
  input  logic             pwr_restored,
  input  logic [CNT_W-1:0] l0s_exit_cyc,
  input  logic [CNT_W-1:0] l1_exit_cyc,
  output logic [2:0]       link_state,
  output logic             tx_eidle,
  output logic             rx_eidle,
  output logic             pll_off,
  output logic             clk_gate,
  output logic             exit_ready,
  output logic             pm_err
);

  localparam int NUM_DIR = 2;

  main_st_e             main_st;
  logic                 main_rdy;
  logic                 lane_allow;
  logic                 lane_force;
  logic [NUM_DIR-1:0]   dir_idle;
  logic [NUM_DIR-1:0]   dir_eidle;
  logic [NUM_DIR-1:0]   dir_rdy;
  logic                 main_active;
  logic                 deep_low;

  assign dir_idle = {rx_idle, tx_idle};

  link_pm_main_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_state   (dev_state),
    .l1_req      (l1_req),
    .no_pending  (no_pending),
    .remove_req  (remove_req),
    .aux_present (aux_present),
    .wake_n      (wake_n),
    .pwr_restored(pwr_restored),
    .exit_len    (l1_exit_cyc),
    .state       (main_st),
    .rdy         (main_rdy),
    .err         (pm_err)
  );

  assign main_active = (main_st == MS_ACTIVE);
  assign lane_allow  = main_active && (dev_state == DEV_ON);
  assign lane_force  = !main_active;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    link_pm_lane #(.CNT_W(CNT_W)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow   (lane_allow),
      .force_on(lane_force),
      .idle    (dir_idle[g]),
      .exit_len(l0s_exit_cyc),
      .eidle   (dir_eidle[g]),
      .rdy     (dir_rdy[g])
    );
  end

  always_comb begin
    unique case (main_st)
      MS_ACTIVE:   link_state = (|dir_eidle) ? CODE_STBY : CODE_ACTIVE;
      MS_LOW,
      MS_LOW_EXIT: link_state = CODE_LOW;
      MS_PREOFF:   link_state = CODE_PREOFF;
      MS_AUXOFF:   link_state = CODE_AUXOFF;
      default:     link_state = CODE_DEAD;
    endcase
  end

  assign deep_low   = !main_active && (main_st != MS_LOW_EXIT);
  assign tx_eidle   = dir_eidle[0] || !main_active;
  assign rx_eidle   = dir_eidle[1] || !main_active;
  assign pll_off    = deep_low;
  assign clk_gate   = !main_active;
  assign exit_ready = main_rdy || ((|dir_rdy) && main_active);

endmodule

// File: rtl/link_pm_ctrl_chk.sv
module link_pm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dev_state,
  input logic       no_pending,
  input logic       wake_n,
  input logic       pwr_restored,
  input logic [2:0] link_state,
  input logic       tx_eidle,
  input logic       rx_eidle,
  input logic       pll_off,
  input logic       clk_gate,
  input logic       exit_ready,
  input logic       pm_err
);

  // R4
  l0s_only_in_d0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd1 && $past(link_state) == 3'd0) |-> ($past(dev_state) == 2'd0));

  // R5
  l1_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd2 && ($past(link_state) == 3'd0 || $past(link_state) == 3'd1))
      |-> $past(no_pending));

  // R6
  pll_off_implies_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off |-> (tx_eidle && rx_eidle && clk_gate));

  // R3
  ready_in_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ready |-> (link_state == 3'd0 || link_state == 3'd1));

  // R9
  l2_exit_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_state) == 3'd4 && link_state != 3'd4) |-> !$past(wake_n));

  // R10
  l3_exit_on_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_state) == 3'd5 && link_state != 3'd5) |-> $past(pwr_restored));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pm_err) |-> pm_err);

endmodule

bind link_pm_ctrl link_pm_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_state   (dev_state),
  .no_pending  (no_pending),
  .wake_n      (wake_n),
  .pwr_restored(pwr_restored),
  .link_state  (link_state),
  .tx_eidle    (tx_eidle),
  .rx_eidle    (rx_eidle),
  .pll_off     (pll_off),
  .clk_gate    (clk_gate),
  .exit_ready  (exit_ready),
  .pm_err      (pm_err)
);

// File: tb/link_pm_ctrl_tb_top.sv
module link_pm_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    dev_state;
  logic          tx_idle, rx_idle, l1_req, no_pending, remove_req;
  logic          aux_present, wake_n, pwr_restored;
  logic [CW-1:0] l0s_exit_cyc, l1_exit_cyc;
  logic [2:0]    link_state;
  logic          tx_eidle, rx_eidle, pll_off, clk_gate, exit_ready, pm_err;

  int    n_vec  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pm_ctrl #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_state(dev_state),
    .tx_idle(tx_idle), .rx_idle(rx_idle), .l1_req(l1_req),
    .no_pending(no_pending), .remove_req(remove_req),
    .aux_present(aux_present), .wake_n(wake_n), .pwr_restored(pwr_restored),
    .l0s_exit_cyc(l0s_exit_cyc), .l1_exit_cyc(l1_exit_cyc),
    .link_state(link_state), .tx_eidle(tx_eidle), .rx_eidle(rx_eidle),
    .pll_off(pll_off), .clk_gate(clk_gate), .exit_ready(exit_ready),
    .pm_err(pm_err)
  );

  // Behavioural reference: main 0 L0, 1 L1, 2 L1 exit, 3 pre-off, 4 L2, 5 L3
  int m_main, m_cnt, m_rdy, m_err;
  int ln_st[2], ln_cnt[2], ln_rdy[2];
  int n_main, n_cnt, n_rdy, n_st, n_lc, n_lr, allow, idl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_main = 0; m_cnt = 0; m_rdy = 0; m_err = 0;
      for (int d = 0; d < 2; d++) begin ln_st[d] = 0; ln_cnt[d] = 0; ln_rdy[d] = 0; end
    end else begin
      allow = (m_main == 0 && dev_state == 0) ? 1 : 0;
      for (int d = 0; d < 2; d++) begin
        idl  = (d == 0) ? int'(tx_idle) : int'(rx_idle);
        n_st = ln_st[d]; n_lc = ln_cnt[d]; n_lr = 0;
        if (m_main != 0) n_st = 0;
        else if (ln_st[d] == 0) begin
          if (allow == 1 && idl == 1) n_st = 1;
        end else if (ln_st[d] == 1) begin
          if (idl == 0 || allow == 0) begin
            n_st = 2;
            n_lc = (l0s_exit_cyc == 0) ? 1 : int'(l0s_exit_cyc);
          end
        end else begin
          if (ln_cnt[d] == 1) begin n_st = 0; n_lr = 1; end
          else n_lc = ln_cnt[d] - 1;
        end
        ln_st[d] = n_st; ln_cnt[d] = n_lc; ln_rdy[d] = n_lr;
      end
      n_main = m_main; n_cnt = m_cnt; n_rdy = 0;
      case (m_main)
        0: begin
          if (remove_req) m_err = 1;
          if ((l1_req || dev_state != 0) && no_pending) n_main = 1;
        end
        1: begin
          if (remove_req) begin
            if (dev_state == 3) n_main = 3; else m_err = 1;
          end else if (dev_state == 0 && !l1_req) begin
            n_main = 2;
            n_cnt  = (l1_exit_cyc == 0) ? 1 : int'(l1_exit_cyc);
          end
        end
        2: begin
          if (remove_req) m_err = 1;
          if (m_cnt == 1) begin n_main = 0; n_rdy = 1; end
          else n_cnt = m_cnt - 1;
        end
        3: if (!remove_req) n_main = aux_present ? 4 : 5;
        4: if (!wake_n) n_main = 0;
        default: if (pwr_restored) n_main = 0;
      endcase
      m_main = n_main; m_cnt = n_cnt; m_rdy = n_rdy;
    end
  end

  function automatic logic [8:0] model_out();
    logic [2:0] ls;
    logic       te, re, po, cg, rd;
    if (m_main == 0)      ls = (ln_st[0] != 0 || ln_st[1] != 0) ? 3'd1 : 3'd0;
    else if (m_main <= 2) ls = 3'd2;
    else                  ls = 3'(m_main);
    te = (ln_st[0] != 0) || (m_main != 0);
    re = (ln_st[1] != 0) || (m_main != 0);
    po = (m_main != 0) && (m_main != 2);
    cg = (m_main != 0);
    rd = (m_rdy == 1) || ((ln_rdy[0] == 1 || ln_rdy[1] == 1) && m_main == 0);
    return {ls, te, re, po, cg, rd, (m_err == 1)};
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic [8:0] act, exp_v;
      act   = {link_state, tx_eidle, rx_eidle, pll_off, clk_gate, exit_ready, pm_err};
      exp_v = model_out();
      n_vec++;
      if (act !== exp_v) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual %b expected %b", cur_req, act, exp_v);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    n_vec++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dev_state = 2'd0; tx_idle = 0; rx_idle = 0; l1_req = 0;
    no_pending = 0; remove_req = 0; aux_present = 0; wake_n = 1; pwr_restored = 0;
    l0s_exit_cyc = CW'(3); l1_exit_cyc = CW'(6);
    tick(3); rst_n = 1'b1; tick(1);

    // R1 reset state
    cur_req = "R1";
    chk("R1", "link_state", int'(link_state), 0);
    chk("R1", "eidle", int'({tx_eidle, rx_eidle}), 0);
    chk("R1", "pll/gate", int'({pll_off, clk_gate}), 0);
    chk("R1", "ready/err", int'({exit_ready, pm_err}), 0);

    // R2 per-direction standby entry
    cur_req = "R2";
    tx_idle = 1; tick(1);
    chk("R2", "tx_eidle", int'(tx_eidle), 1);
    chk("R2", "rx_eidle", int'(rx_eidle), 0);
    chk("R2", "link_state", int'(link_state), 1);
    tick(2); rx_idle = 1; tick(1);
    chk("R2", "rx_eidle", int'(rx_eidle), 1);

    // R3 exit latency of one direction while the other stays idle
    cur_req = "R3";
    tx_idle = 0; tick(3);
    chk("R3", "tx_eidle during exit", int'(tx_eidle), 1);
    tick(1);
    chk("R3", "tx_eidle after exit", int'(tx_eidle), 0);
    chk("R3", "exit_ready", int'(exit_ready), 1);
    chk("R3", "link_state", int'(link_state), 1);
    tick(1);
    chk("R3", "ready one cycle", int'(exit_ready), 0);
    rx_idle = 0; tick(4);
    chk("R3", "rx exit ready", int'(exit_ready), 1);
    chk("R3", "link back to L0", int'(link_state), 0);

    // R4 no standby outside D0
    cur_req = "R4";
    dev_state = 2'd1; no_pending = 0; tx_idle = 1; tick(3);
    chk("R4", "tx_eidle in D1", int'(tx_eidle), 0);
    chk("R4", "link_state", int'(link_state), 0);
    dev_state = 2'd0; tick(1);
    chk("R4", "entry once D0", int'(tx_eidle), 1);
    // R3 zero-length exit clamps to one cycle
    cur_req = "R3";
    l0s_exit_cyc = '0; tx_idle = 0; tick(1);
    chk("R3", "zero len exit window", int'(tx_eidle), 1);
    tick(1);
    chk("R3", "zero len ready", int'(exit_ready), 1);
    chk("R3", "zero len eidle", int'(tx_eidle), 0);
    cur_req = "R4";
    tx_idle = 1; tick(2);
    dev_state = 2'd1; tick(2);
    chk("R4", "exit forced by D-state", int'(tx_eidle), 0);
    dev_state = 2'd0; tx_idle = 0; l0s_exit_cyc = CW'(3); tick(1);

    // R5 directed L1 entry waits for quiet
    cur_req = "R5";
    l1_req = 1; no_pending = 0; tick(3);
    chk("R5", "pending blocks L1", int'(link_state), 0);
    no_pending = 1; tick(1);
    chk("R5", "L1 entered", int'(link_state), 2);
    cur_req = "R6";
    chk("R6", "pll_off in L1", int'(pll_off), 1);
    chk("R6", "clk_gate in L1", int'(clk_gate), 1);
    chk("R6", "eidle in L1", int'({tx_eidle, rx_eidle}), 3);

    // R7 L1 exit
    cur_req = "R7";
    l1_req = 0; tick(1);
    chk("R7", "exit window state", int'(link_state), 2);
    chk("R7", "pll on during exit", int'(pll_off), 0);
    chk("R7", "gate during exit", int'(clk_gate), 1);
    tick(5);
    chk("R7", "still exiting", int'(link_state), 2);
    tick(1);
    chk("R7", "back to L0", int'(link_state), 0);
    chk("R7", "exit_ready", int'(exit_ready), 1);
    dev_state = 2'd3; tick(1);
    chk("R5", "L1 forced by D3hot", int'(link_state), 2);
    tick(4);
    chk("R7", "no exit outside D0", int'(link_state), 2);

    // R8 pre-removal then L2
    cur_req = "R8";
    remove_req = 1; aux_present = 1; tick(1);
    chk("R8", "L2/L3-Ready", int'(link_state), 3);
    tick(3);
    chk("R8", "held while requested", int'(link_state), 3);
    chk("R6", "pll_off pre-off", int'(pll_off), 1);
    remove_req = 0; tick(1);
    chk("R8", "to L2 with aux", int'(link_state), 4);

    // R9 L2 leaves only on wake
    cur_req = "R9";
    pwr_restored = 1; tick(2);
    chk("R9", "restore ignored in L2", int'(link_state), 4);
    pwr_restored = 0; dev_state = 2'd0; wake_n = 0; tick(1);
    chk("R9", "wake to L0", int'(link_state), 0);
    chk("R9", "no ready on wake", int'(exit_ready), 0);
    wake_n = 1;

    // R10 L3 leaves only on power reapplied
    cur_req = "R10";
    dev_state = 2'd3; tick(1);
    remove_req = 1; aux_present = 0; tick(1);
    remove_req = 0; tick(1);
    chk("R8", "to L3 without aux", int'(link_state), 5);
    wake_n = 0; tick(2);
    chk("R10", "wake ignored in L3", int'(link_state), 5);
    chk("R11", "no error so far", int'(pm_err), 0);
    wake_n = 1; dev_state = 2'd0; pwr_restored = 1; tick(1);
    chk("R10", "restore to L0", int'(link_state), 0);
    pwr_restored = 0;

    // R11 illegal removal requests
    cur_req = "R11";
    dev_state = 2'd2; tick(1);
    chk("R11", "L1 in D2", int'(link_state), 2);
    remove_req = 1; tick(1);
    chk("R11", "request ignored", int'(link_state), 2);
    chk("R11", "error set", int'(pm_err), 1);
    remove_req = 0; dev_state = 2'd0; tick(10);
    chk("R11", "error sticky", int'(pm_err), 1);
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    chk("R11", "error cleared by reset", int'(pm_err), 0);
    remove_req = 1; tick(1);
    chk("R11", "error from L0", int'(pm_err), 1);
    chk("R11", "L0 kept", int'(link_state), 0);
    remove_req = 0; tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule